// File: doc/BRIEF.md
# Per-Port Bus Security Gate

This block sits between one bus requester and a small set of peripheral ports. Each request names a target port and carries a Non-secure attribute bit. The gate checks that bit against the security policy of the target port. It then does one of two things. It forwards the request, raising a one-hot select toward that port and holding it until the port acknowledges. Or it rejects the request and answers it locally with an error response. A rejected request never reaches the peripheral.

Each port has a fixed policy, set by a 2-bit field in the `PORT_MODES` parameter at position `2*i`. The encodings are:

| Code | Policy |
|------|--------|
| 00 | Secure only |
| 01 | Non-secure only |
| 10 | Boot-programmable |
| 11 | Security-aware pass-through |

A boot-programmable port also has a runtime bit, held in a small configuration space. A Secure access can program that bit and can then freeze the whole space with a sticky lock. A saturating counter for each port records how many of its accesses were rejected. Software reads these counters through the same configuration space.

The gate handles one transaction at a time. `reqReady` is high only while the gate is idle. Each response is a single-cycle pulse on `rspValid`.

Top module: `secGate`

## Requirements
- R1: A port with policy 00 forwards a request only when `reqNs`=0. A request with `reqNs`=1 to that port is rejected.
- R2: A port with policy 01 forwards a request only when `reqNs`=1. A request with `reqNs`=0 to that port is rejected.
- R3: A port with policy 10 forwards a request only when `reqNs` equals its runtime bit. Every runtime bit is 0 (Secure) after reset.
- R4: A port with policy 11 forwards every request. On every forwarded request, `perNs`, `perWrite`, `perAddr` and `perWdata` carry the accepted request's values unchanged.
- R5: A rejected request never asserts any `perSel` bit. In the cycle after acceptance, `rspValid`=1, `rspErr`=1 and `rspRdata`=0.
- R6: A forwarded request raises only `perSel[port]`, in the cycle after acceptance, and holds it until `perAck[port]`. In the cycle after the acknowledge, `rspValid`=1, `rspErr`=0, and `rspRdata` holds the port's `perRdata` slice sampled at the acknowledge.
- R7: A Secure (`cfgNs`=0) write to config address 0, while unlocked, loads `cfgWdata` bit i into the runtime bit of port i. This applies only to ports with policy 10; all other runtime bits stay 0. A read of address 0 returns the lock in bit 7 and runtime bit i in bit i.
- R8: A config write with `cfgNs`=1 changes no state and answers with `cfgRspErr`=1.
- R9: A Secure write to address 0 with bit 7 set sets the lock. The lock stays set until reset. While it is set, every config write changes nothing and answers with `cfgRspErr`=1.
- R10: Config address 1+i reads the rejected-access count of port i. The count is 8 bits and stops at 255. Writes to these addresses answer with an error. Reads of addresses above the port count return 0 with an error.
- R11: Every config access gets a response on `cfgRspValid` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Gate idle, request accepted this cycle if valid |
| reqPort | input | PORT_W | Target port index |
| reqNs | input | 1 | Non-secure attribute of the request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Address within the port |
| reqWdata | input | DATA_W | Write data |
| rspValid | output | 1 | Response pulse |
| rspErr | output | 1 | Response is a security rejection |
| rspRdata | output | DATA_W | Read data, zero on rejection |
| perSel | output | NUM_PORTS | One-hot peripheral select |
| perNs | output | 1 | Forwarded Non-secure attribute |
| perWrite | output | 1 | Forwarded direction |
| perAddr | output | ADDR_W | Forwarded address |
| perWdata | output | DATA_W | Forwarded write data |
| perAck | input | NUM_PORTS | Per-port completion |
| perRdata | input | NUM_PORTS*DATA_W | Per-port read data, port i at bits i*DATA_W |
| cfgValid | input | 1 | Config access present |
| cfgWrite | input | 1 | Config write |
| cfgNs | input | 1 | Non-secure attribute of the config access |
| cfgAddr | input | CFG_AW | Config address |
| cfgWdata | input | CFG_DW | Config write data |
| cfgRspValid | output | 1 | Config response pulse |
| cfgRspErr | output | 1 | Config access refused or out of range |
| cfgRdata | output | CFG_DW | Config read data |

## Verification
Suppose the gate kept a wrong runtime bit or lock value. The first request to the boot-programmable port after that would be forwarded where it should be rejected, or the reverse. The mismatch shows up on `perSel` or `rspErr` one cycle after acceptance. A readback of address 0 also shows it in the next cycle.

A fault counter that miscounts is invisible on the request path. It only appears when the counter is read, so the bench reads all counters after each sweep. It also drives one port's count past 255 to exercise saturation.

// File: rtl/secGatePkg.sv
package secGatePkg;

  typedef enum logic [1:0] {
    MODE_SEC   = 2'b00,
    MODE_NSEC  = 2'b01,
    MODE_BOOT  = 2'b10,
    MODE_AWARE = 2'b11
  } portMode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FWD,
    ST_RSP,
    ST_FAULT
  } gateState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;    // request taken this cycle
    logic faultHit;  // taken request is rejected
    logic rspLoad;   // peripheral acknowledged, capture read data
  } gateStrobe_t;

  function automatic logic accessAllowed(input logic [1:0] mode, input logic runNs,
                                         input logic ns);
    case (mode)
      MODE_SEC:  return !ns;
      MODE_NSEC: return ns;
      MODE_BOOT: return ns == runNs;
      default:   return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/secGateCtrl.sv
module secGateCtrl
  import secGatePkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W = 2,
  parameter logic [2*NUM_PORTS-1:0] PORT_MODES = 8'b11_10_01_00
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [PORT_W-1:0]    reqPort,
  input  logic                 reqNs,
  input  logic [NUM_PORTS-1:0] runtimeNs,
  input  logic [PORT_W-1:0]    heldPort,
  input  logic [NUM_PORTS-1:0] perAck,
  output logic                 reqReady,
  output logic [NUM_PORTS-1:0] perSel,
  output logic                 rspValid,
  output logic                 rspErr,
  output gateStrobe_t          strobe
);

  gateState_e state, stateNext;
  logic [1:0] tgtMode;
  logic tgtRun, tgtHit, permit, accept, ackHit;

  always_comb begin
    tgtMode = '0;
    tgtRun  = 1'b0;
    tgtHit  = 1'b0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (reqPort == PORT_W'(i)) begin
        tgtMode = PORT_MODES[2*i +: 2];
        tgtRun  = runtimeNs[i];
        tgtHit  = 1'b1;
      end
    end
  end

  assign permit   = tgtHit && accessAllowed(tgtMode, tgtRun, reqNs);
  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;

  always_comb begin
    ackHit = 1'b0;
    perSel = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (heldPort == PORT_W'(i)) begin
        ackHit    = perAck[i];
        perSel[i] = (state == ST_FWD);
      end
    end
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (accept) stateNext = permit ? ST_FWD : ST_FAULT;
      ST_FWD:   if (ackHit) stateNext = ST_RSP;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign rspValid        = (state == ST_RSP) || (state == ST_FAULT);
  assign rspErr          = (state == ST_FAULT);
  assign strobe.accept   = accept;
  assign strobe.faultHit = accept && !permit && tgtHit;
  assign strobe.rspLoad  = (state == ST_FWD) && ackHit;

  // R6: at most one port selected
  p_sel_onehot_r6: assert property (@(posedge clk) disable iff (!rstN) $onehot0(perSel));

  // R5: rejection answered next cycle, nothing shown to peripherals
  p_fault_rsp_r5: assert property (@(posedge clk) disable iff (!rstN)
    accept && !permit |=> rspValid && rspErr && (perSel == '0));

  // R6: permitted request selects a port next cycle, no early response
  p_fwd_sel_r6: assert property (@(posedge clk) disable iff (!rstN)
    accept && permit |=> !rspValid && (perSel != '0));

  // R6: response after acknowledge is error free
  p_ack_rsp_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((perSel & perAck) != '0) |=> rspValid && !rspErr);

endmodule

// File: rtl/secGateData.sv
module secGateData
  import secGatePkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W = 8,
  parameter int CFG_AW = 3,
  parameter int CFG_DW = 8,
  parameter logic [2*NUM_PORTS-1:0] PORT_MODES = 8'b11_10_01_00
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  gateStrobe_t                 strobe,
  input  logic [PORT_W-1:0]           reqPort,
  input  logic                        reqNs,
  input  logic                        reqWrite,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [DATA_W-1:0]           reqWdata,
  input  logic [NUM_PORTS*DATA_W-1:0] perRdata,
  input  logic                        cfgValid,
  input  logic                        cfgWrite,
  input  logic                        cfgNs,
  input  logic [CFG_AW-1:0]           cfgAddr,
  input  logic [CFG_DW-1:0]           cfgWdata,
  output logic [PORT_W-1:0]           heldPort,
  output logic                        perNs,
  output logic                        perWrite,
  output logic [ADDR_W-1:0]           perAddr,
  output logic [DATA_W-1:0]           perWdata,
  output logic [DATA_W-1:0]           rspRdata,
  output logic [NUM_PORTS-1:0]        runtimeNs,
  output logic                        cfgRspValid,
  output logic                        cfgRspErr,
  output logic [CFG_DW-1:0]           cfgRdata
);

  localparam int LOCK_BIT = CFG_DW - 1;

  function automatic logic [NUM_PORTS-1:0] bootMaskOf();
    logic [NUM_PORTS-1:0] m;
    for (int i = 0; i < NUM_PORTS; i++) m[i] = (PORT_MODES[2*i +: 2] == MODE_BOOT);
    return m;
  endfunction
  localparam logic [NUM_PORTS-1:0] BOOT_MASK = bootMaskOf();

  logic lockReg, cfgSecWr, addrOk;
  logic [CFG_DW-1:0] rdNext;
  logic [CNT_W-1:0] faultCnt [NUM_PORTS];
  logic unusedCfgBits;

  assign unusedCfgBits = ^cfgWdata;

  // request hold and response data
  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldPort <= '0;
      perNs    <= 1'b0;
      perWrite <= 1'b0;
      perAddr  <= '0;
      perWdata <= '0;
      rspRdata <= '0;
    end else if (strobe.accept) begin
      heldPort <= reqPort;
      perNs    <= reqNs;
      perWrite <= reqWrite;
      perAddr  <= reqAddr;
      perWdata <= reqWdata;
      rspRdata <= '0;
    end else if (strobe.rspLoad) begin
      for (int i = 0; i < NUM_PORTS; i++)
        if (heldPort == PORT_W'(i)) rspRdata <= perRdata[i*DATA_W +: DATA_W];
    end
  end

  // saturating rejection counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PORTS; i++) faultCnt[i] <= '0;
    end else if (strobe.faultHit) begin
      for (int i = 0; i < NUM_PORTS; i++)
        if (reqPort == PORT_W'(i) && faultCnt[i] != '1) faultCnt[i] <= faultCnt[i] + 1'b1;
    end
  end

  // configuration space
  assign cfgSecWr = cfgValid && cfgWrite && !cfgNs && !lockReg && (cfgAddr == '0);

  always_comb begin
    rdNext = '0;
    addrOk = 1'b0;
    if (cfgAddr == '0) begin
      rdNext[LOCK_BIT]        = lockReg;
      rdNext[NUM_PORTS-1:0]   = runtimeNs;
      addrOk                  = 1'b1;
    end
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (cfgAddr == CFG_AW'(i + 1)) begin
        rdNext = CFG_DW'(faultCnt[i]);
        addrOk = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runtimeNs   <= '0;
      lockReg     <= 1'b0;
      cfgRspValid <= 1'b0;
      cfgRspErr   <= 1'b0;
      cfgRdata    <= '0;
    end else begin
      if (cfgSecWr) begin
        runtimeNs <= cfgWdata[NUM_PORTS-1:0] & BOOT_MASK;
        if (cfgWdata[LOCK_BIT]) lockReg <= 1'b1;
      end
      cfgRspValid <= cfgValid;
      cfgRspErr   <= cfgValid && (cfgWrite ? !cfgSecWr : !addrOk);
      cfgRdata    <= (cfgValid && !cfgWrite && addrOk) ? rdNext : '0;
    end
  end

  // R9: lock is sticky
  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rstN) lockReg |=> lockReg);

  // R9: runtime bits frozen under lock
  p_runtime_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    lockReg |=> $stable(runtimeNs));

  // R8: Non-secure config writes change nothing and report an error
  p_ns_cfg_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid && cfgWrite && cfgNs |=> $stable(runtimeNs) && cfgRspErr);

  // R7: only boot-programmable ports ever carry a runtime bit
  p_boot_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    (runtimeNs & ~BOOT_MASK) == '0);

  // R10: a full counter stays full
  for (genvar g = 0; g < NUM_PORTS; g++) begin : gSat
    p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rstN)
      faultCnt[g] == '1 |=> faultCnt[g] == '1);
  end

endmodule

// File: rtl/secGate.sv
module secGate
  import secGatePkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W = 8,
  parameter int CFG_AW = 3,
  parameter int CFG_DW = 8,
  parameter logic [2*NUM_PORTS-1:0] PORT_MODES = 8'b11_10_01_00
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  output logic                        reqReady,
  input  logic [PORT_W-1:0]           reqPort,
  input  logic                        reqNs,
  input  logic                        reqWrite,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [DATA_W-1:0]           reqWdata,
  output logic                        rspValid,
  output logic                        rspErr,
  output logic [DATA_W-1:0]           rspRdata,
  output logic [NUM_PORTS-1:0]        perSel,
  output logic                        perNs,
  output logic                        perWrite,
  output logic [ADDR_W-1:0]           perAddr,
  output logic [DATA_W-1:0]           perWdata,
  input  logic [NUM_PORTS-1:0]        perAck,
  input  logic [NUM_PORTS*DATA_W-1:0] perRdata,
  input  logic                        cfgValid,
  input  logic                        cfgWrite,
  input  logic                        cfgNs,
  input  logic [CFG_AW-1:0]           cfgAddr,
  input  logic [CFG_DW-1:0]           cfgWdata,
  output logic                        cfgRspValid,
  output logic                        cfgRspErr,
  output logic [CFG_DW-1:0]           cfgRdata
);

  gateStrobe_t strobe;
  logic [NUM_PORTS-1:0] runtimeNs;
  logic [PORT_W-1:0] heldPort;

  secGateCtrl #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .PORT_MODES(PORT_MODES)
  ) ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPort(reqPort), .reqNs(reqNs),
    .runtimeNs(runtimeNs), .heldPort(heldPort), .perAck(perAck), .reqReady(reqReady),
    .perSel(perSel), .rspValid(rspValid), .rspErr(rspErr), .strobe(strobe)
  );

  secGateData #(
    .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CNT_W(CNT_W), .CFG_AW(CFG_AW), .CFG_DW(CFG_DW), .PORT_MODES(PORT_MODES)
  ) data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqPort(reqPort), .reqNs(reqNs),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .perRdata(perRdata),
    .cfgValid(cfgValid), .cfgWrite(cfgWrite), .cfgNs(cfgNs), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .heldPort(heldPort), .perNs(perNs), .perWrite(perWrite),
    .perAddr(perAddr), .perWdata(perWdata), .rspRdata(rspRdata), .runtimeNs(runtimeNs),
    .cfgRspValid(cfgRspValid), .cfgRspErr(cfgRspErr), .cfgRdata(cfgRdata)
  );

  // R4: the attribute reaching the peripheral is the one the requester sent
  p_ns_pass_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|perSel) |-> perNs == $past(reqNs) && perWrite == $past(reqWrite));

endmodule

// File: tb/secGate_test.sv
module secGate_test;

  localparam int NP = 4;
  localparam int PW = 2;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int CAW = 3;
  localparam int CDW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqNs = 1'b0, reqWrite = 1'b0;
  logic [PW-1:0] reqPort = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqReady, rspValid, rspErr;
  logic [DW-1:0] rspRdata;
  logic [NP-1:0] perSel;
  logic perNs, perWrite;
  logic [AW-1:0] perAddr;
  logic [DW-1:0] perWdata;
  logic [NP-1:0] perAck = '0;
  logic [NP*DW-1:0] perRdata = '0;
  logic cfgValid = 1'b0, cfgWrite = 1'b0, cfgNs = 1'b0;
  logic [CAW-1:0] cfgAddr = '0;
  logic [CDW-1:0] cfgWdata = '0;
  logic cfgRspValid, cfgRspErr;
  logic [CDW-1:0] cfgRdata;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  logic expRun2 = 1'b0;       // model of the runtime bit of port 2
  logic expLock = 1'b0;
  int expCnt [NP];
  int txnIdx = 0;

  always #2 clk = ~clk;       // 250 MHz

  secGate #(.PORT_MODES(8'b11_10_01_00)) uut (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit modelAllow(input int p, input bit ns);
    case (p)
      0: return !ns;            // R1
      1: return ns;             // R2
      2: return ns == expRun2;  // R3
      default: return 1'b1;     // R4
    endcase
  endfunction

  // called at a negedge with the gate idle; returns at a negedge with the gate idle
  task automatic doReq(input int p, input bit ns, input bit wr, input int lag);
    logic [DW-1:0] wd, rd;
    logic [AW-1:0] ad;
    bit allow;
    txnIdx++;
    ad = AW'(txnIdx * 7);
    wd = {8'h5A, 8'(p), 8'(txnIdx), 8'(ns)};
    rd = {8'hA5, 8'(p), 8'(txnIdx >> 8), 8'(txnIdx)};
    allow = modelAllow(p, ns);
    reqValid = 1'b1; reqPort = PW'(p); reqNs = ns; reqWrite = wr; reqAddr = ad; reqWdata = wd;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (!allow) begin
      if (p < NP && expCnt[p] < 255) expCnt[p]++;
      check(perSel == '0 && rspValid && rspErr && rspRdata == '0,
            (p == 0) ? "R5/R1 reject" : (p == 1) ? "R5/R2 reject" : "R5/R3 reject",
            {perSel, rspValid, rspErr, rspRdata}, {4'b0, 1'b1, 1'b1, 32'h0});
      @(negedge clk);
    end else begin
      check(perSel == NP'(1 << p) && !rspValid, "R6 select",
            {perSel, rspValid}, {NP'(1 << p), 1'b0});
      check(perNs == ns && perWrite == wr && perAddr == ad && perWdata == wd, "R4 forwarded fields",
            {perNs, perWrite, perAddr, perWdata}, {ns, wr, ad, wd});
      for (int k = 0; k < lag; k++) begin
        @(negedge clk);
        check(perSel == NP'(1 << p) && !rspValid, "R6 select held", perSel, NP'(1 << p));
      end
      perAck[p] = 1'b1;
      perRdata[p*DW +: DW] = rd;
      @(negedge clk);
      perAck = '0;
      check(rspValid && !rspErr && rspRdata == rd && perSel == '0, "R6 response",
            {rspValid, rspErr, rspRdata}, {1'b1, 1'b0, rd});
      @(negedge clk);
    end
  endtask

  task automatic cfgAcc(input bit wr, input bit ns, input int addr, input logic [CDW-1:0] wd,
                        input bit expErr, input logic [CDW-1:0] expRd, input string req);
    cfgValid = 1'b1; cfgWrite = wr; cfgNs = ns; cfgAddr = CAW'(addr); cfgWdata = wd;
    @(negedge clk);
    cfgValid = 1'b0;
    check(cfgRspValid, "R11 config response", cfgRspValid, 1);
    check(cfgRspErr == expErr && (wr || cfgRdata == expRd), req,
          {cfgRspErr, cfgRdata}, {expErr, expRd});
    @(negedge clk);
  endtask

  task automatic sweep();
    for (int p = 0; p < NP; p++)
      for (int ns = 0; ns < 2; ns++)
        for (int wr = 0; wr < 2; wr++)
          doReq(p, ns[0], wr[0], (p + wr) % 3);
  endtask

  task automatic readCounters();
    for (int p = 0; p < NP; p++)
      cfgAcc(1'b0, 1'b1, p + 1, '0, 1'b0, CDW'(expCnt[p]), "R10 counter read");
  endtask

  initial begin
    for (int p = 0; p < NP; p++) expCnt[p] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !rspValid && perSel == '0 && !cfgRspValid, "R5 reset state",
          {reqReady, rspValid, perSel, cfgRspValid}, {1'b1, 1'b0, 4'b0, 1'b0});
    cfgAcc(1'b0, 1'b0, 0, '0, 1'b0, 8'h00, "R3 runtime resets Secure");
    readCounters();

    sweep();
    readCounters();

    // R7: secure write; only port 2 keeps its bit
    cfgAcc(1'b1, 1'b0, 0, 8'h0F, 1'b0, '0, "R7 secure write accepted");
    expRun2 = 1'b1;
    cfgAcc(1'b0, 1'b1, 0, '0, 1'b0, 8'h04, "R7 readback");
    sweep();

    // R8: non-secure write ignored
    cfgAcc(1'b1, 1'b1, 0, 8'h00, 1'b1, '0, "R8 non-secure write refused");
    cfgAcc(1'b0, 1'b0, 0, '0, 1'b0, 8'h04, "R8 state unchanged");
    doReq(2, 1'b1, 1'b0, 0);   // still forwards with runtime bit 1
    doReq(2, 1'b0, 1'b1, 0);   // still rejects Secure

    // R10: counters are read only, out-of-range address
    cfgAcc(1'b1, 1'b0, 1, 8'h00, 1'b1, '0, "R10 counter write refused");
    cfgAcc(1'b0, 1'b0, 7, '0, 1'b1, 8'h00, "R10 out-of-range read");
    readCounters();

    // R9: lock together with clearing port 2 back to Secure
    cfgAcc(1'b1, 1'b0, 0, 8'h80, 1'b0, '0, "R9 lock write accepted");
    expRun2 = 1'b0; expLock = 1'b1;
    cfgAcc(1'b0, 1'b0, 0, '0, 1'b0, 8'h80, "R9 lock readback");
    cfgAcc(1'b1, 1'b0, 0, 8'h04, 1'b1, '0, "R9 locked write refused");
    cfgAcc(1'b1, 1'b0, 0, 8'h00, 1'b1, '0, "R9 locked unlock attempt refused");
    cfgAcc(1'b0, 1'b0, 0, '0, 1'b0, 8'h80, "R9 state frozen");
    sweep();

    // R10: saturation on port 0
    for (int n = 0; n < 300; n++) doReq(0, 1'b1, n[0], 0);
    readCounters();
    doReq(3, 1'b1, 1'b0, 2);   // R4 aware port still forwards
    readCounters();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule